// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block produces the line and frame timing of a dot-matrix LCD controller. A clock-enable tick from an upstream prescaler drives all counting. A horizontal line lasts a number of ticks equal to a shift count times one plus a programmable horizontal timing value. The shift count follows the horizontal dot size: 40 for a 160-dot line and 50 for a 200-dot line. A frame is a coded number of visible lines followed by a programmable number of vertical blanking lines. After the last blank line the line counter returns to zero.

The block raises a one-cycle interrupt when the first blank line begins. It exposes an 8-bit status view with a blank flag. All configuration inputs are captured at frame boundaries, so one frame always runs on a single consistent set of values. The control is a three-state machine. ST_IDLE is held from reset until the first tick, which captures the configuration (transition START). ST_ACTIVE counts visible lines. It moves to ST_BLANK when the last visible line ends and the blank width is non-zero (transition ENTER_BLANK, which fires the interrupt). If the width is zero it stays in ST_ACTIVE and starts a new frame (transition WRAP_NO_BLANK). ST_BLANK counts blank lines and returns to ST_ACTIVE after the last one (transition WRAP_FRAME).

Top module: `lcd_frame_timer`

## Requirements
- R1: After reset, line_stb, frame_stb, irq and vblank are 0 and status reads 8'h00. The block stays idle, with no strobes, until the first tick. That first tick captures the configuration and starts line 0 of a frame without counting as a line tick.
- R2: A line lasts S×(htime+1) ticks, where S is 40 when dot_sel=0 and 50 when dot_sel=1. Only cycles with tick=1 count toward the line. line_stb is a one-cycle pulse in the cycle after the tick that completes the line.
- R3: The visible line count follows size code vsize: 2'b00 gives 100 lines, 2'b01 gives 160 lines, 2'b10 gives 200 lines, and the reserved code 2'b11 gives 200 lines.
- R4: After the visible lines come vwidth blank lines, with vblank=1 during them. A frame therefore lasts visible+vwidth lines, after which the line counter restarts at 0 in the visible period.
- R5: irq is a one-cycle pulse that is raised in the same cycle that vblank rises, once per frame.
- R6: When the blank width in use is 4'b0000, no irq is raised, vblank stays 0 and frames consist of visible lines only.
- R7: htime, dot_sel, vsize and vwidth are sampled only at the first tick after reset and at each frame end. Changing them mid-frame has no effect on the current frame or on the status view.
- R8: frame_stb is a one-cycle pulse that coincides with the line_stb of the frame's last line.
- R9: status bit 7 equals vblank, bit 6 reads 0, bits 5:4 hold the size code in use and bits 3:0 hold the blank width in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable from the prescaler |
| htime | input | 8 | Horizontal timing factor (line = S×(htime+1) ticks) |
| dot_sel | input | 1 | Dot size: 0 = 160 dots, 1 = 200 dots |
| vsize | input | 2 | Visible line count code |
| vwidth | input | 4 | Vertical blank width in lines |
| line_stb | output | 1 | End-of-line pulse |
| frame_stb | output | 1 | End-of-frame pulse |
| vblank | output | 1 | High during blank lines |
| irq | output | 1 | Pulse at blank entry |
| status | output | 8 | Read-only vertical status view |

## Verification
The bench targets several corner cases, each with the fault it would expose:
- Blank width zero: a design that ignored this case would pulse irq or sit in a blank line of zero length.
- Reserved size code 11: a wrong decode would give a frame of the wrong number of lines.
- Configuration changes made mid-frame: a design without capture at frame boundaries would change line length or status in the middle of a frame.
- Sparse ticks: a design that counted raw clock cycles would end lines early.

Frame line counts and interrupt counts are also tallied at each frame_stb. An off-by-one in the visible or blank boundary therefore shows up as a wrong total even when each single strobe looks plausible.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int DOT_W        = 6;
    localparam int SHIFT_NARROW = 40;
    localparam int SHIFT_WIDE   = 50;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_BLANK  = 2'd2
    } lcdt_state_e;

    function automatic logic [DOT_W-1:0] shift_count(input logic wide);
        return wide ? DOT_W'(SHIFT_WIDE) : DOT_W'(SHIFT_NARROW);
    endfunction

    function automatic logic [7:0] visible_lines(input logic [1:0] code);
        logic [7:0] n;
        unique case (code)
            2'b00:   n = 8'd100;
            2'b01:   n = 8'd160;
            default: n = 8'd200;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lcdt_cfg_shadow.sv
module lcdt_cfg_shadow #(
    parameter int HT_W = 8,
    parameter int BW_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [HT_W-1:0] htime_in,
    input  logic            dot_in,
    input  logic [1:0]      vsize_in,
    input  logic [BW_W-1:0] vwidth_in,
    output logic [HT_W-1:0] htime_q,
    output logic            dot_q,
    output logic [1:0]      vsize_q,
    output logic [BW_W-1:0] vwidth_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htime_q  <= '0;
            dot_q    <= 1'b0;
            vsize_q  <= 2'b00;
            vwidth_q <= '0;
        end else if (load) begin
            htime_q  <= htime_in;
            dot_q    <= dot_in;
            vsize_q  <= vsize_in;
            vwidth_q <= vwidth_in;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({htime_q, dot_q, vsize_q, vwidth_q})); // R7

endmodule

// File: rtl/lcdt_line_timer.sv
module lcdt_line_timer
    import lcdt_pkg::*;
#(
    parameter int HT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            dot_sel,
    input  logic [HT_W-1:0] htime,
    output logic            line_end
);

    logic [DOT_W-1:0] dot_cnt;
    logic [HT_W-1:0]  rep_cnt;
    logic [DOT_W-1:0] shift_n;
    logic             dot_last;
    logic             rep_last;

    assign shift_n  = shift_count(dot_sel);
    assign dot_last = (dot_cnt == shift_n - DOT_W'(1));
    assign rep_last = (rep_cnt == htime);
    assign line_end = run && tick && dot_last && rep_last;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dot_cnt <= '0;
            rep_cnt <= '0;
        end else if (tick) begin
            if (dot_last) begin
                dot_cnt <= '0;
                rep_cnt <= rep_last ? '0 : rep_cnt + HT_W'(1);
            end else begin
                dot_cnt <= dot_cnt + DOT_W'(1);
            end
        end
    end

    AST_DOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (dot_cnt < shift_n)); // R2

    AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (rep_cnt <= htime)); // R2

endmodule

// File: rtl/lcdt_frame_fsm.sv
module lcdt_frame_fsm
    import lcdt_pkg::*;
#(
    parameter int BW_W = 4,
    parameter int LN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            line_end,
    input  logic [1:0]      vsize,
    input  logic [BW_W-1:0] vwidth,
    output lcdt_state_e     state,
    output logic            load,
    output logic            line_stb,
    output logic            frame_stb,
    output logic            irq
);

    lcdt_state_e     nxt;
    logic [LN_W-1:0] ln;
    logic [LN_W-1:0] vis;
    logic [LN_W-1:0] total;
    logic            last_vis;
    logic            last_all;
    logic            no_blank;
    logic            frame_end;

    assign vis      = LN_W'(visible_lines(vsize));
    assign total    = vis + LN_W'(vwidth);
    assign last_vis = (ln == vis - LN_W'(1));
    assign last_all = (ln == total - LN_W'(1));
    assign no_blank = (vwidth == '0);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick) nxt = ST_ACTIVE;
            ST_ACTIVE: if (line_end && last_vis && !no_blank) nxt = ST_BLANK;
            ST_BLANK:  if (line_end && last_all) nxt = ST_ACTIVE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign frame_end = line_end &&
                       (((state == ST_ACTIVE) && last_vis && no_blank) ||
                        ((state == ST_BLANK) && last_all));
    assign load = ((state == ST_IDLE) && tick) || frame_end;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        ln <= '0;
        else if (load)     ln <= '0;
        else if (line_end) ln <= ln + LN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_stb  <= 1'b0;
            frame_stb <= 1'b0;
            irq       <= 1'b0;
        end else begin
            line_stb  <= line_end;
            frame_stb <= frame_end;
            irq       <= (state == ST_ACTIVE) && (nxt == ST_BLANK);
        end
    end

    AST_IRQ_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (state == ST_BLANK)); // R5

    AST_IRQ_NEEDS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vwidth != '0)); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5

    AST_FRAME_WITH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> line_stb); // R8

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> ((ln == '0) && (state == ST_ACTIVE))); // R4

    AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (ln < total)); // R4

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcdt_pkg::*;
#(
    parameter int HT_W = 8,
    parameter int BW_W = 4,
    parameter int LN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [HT_W-1:0] htime,
    input  logic            dot_sel,
    input  logic [1:0]      vsize,
    input  logic [BW_W-1:0] vwidth,
    output logic            line_stb,
    output logic            frame_stb,
    output logic            vblank,
    output logic            irq,
    output logic [7:0]      status
);

    localparam int PAD_W = 6 - BW_W - 2;

    logic [HT_W-1:0] cfg_htime;
    logic            cfg_dot;
    logic [1:0]      cfg_vsize;
    logic [BW_W-1:0] cfg_vwidth;
    logic            load;
    logic            line_end;
    lcdt_state_e     state;

    lcdt_cfg_shadow #(.HT_W(HT_W), .BW_W(BW_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .htime_in  (htime),
        .dot_in    (dot_sel),
        .vsize_in  (vsize),
        .vwidth_in (vwidth),
        .htime_q   (cfg_htime),
        .dot_q     (cfg_dot),
        .vsize_q   (cfg_vsize),
        .vwidth_q  (cfg_vwidth)
    );

    lcdt_line_timer #(.HT_W(HT_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state != ST_IDLE),
        .tick     (tick),
        .dot_sel  (cfg_dot),
        .htime    (cfg_htime),
        .line_end (line_end)
    );

    lcdt_frame_fsm #(.BW_W(BW_W), .LN_W(LN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .line_end  (line_end),
        .vsize     (cfg_vsize),
        .vwidth    (cfg_vwidth),
        .state     (state),
        .load      (load),
        .line_stb  (line_stb),
        .frame_stb (frame_stb),
        .irq       (irq)
    );

    assign vblank = (state == ST_BLANK);

    generate
        if (PAD_W > 0) begin : g_pad
            assign status = {vblank, 1'b0, cfg_vsize, {PAD_W{1'b0}}, cfg_vwidth};
        end else begin : g_nopad
            assign status = {vblank, 1'b0, cfg_vsize, cfg_vwidth[3:0]};
        end
    endgenerate

    AST_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] == 1'b0); // R9

    AST_VBLANK_ONLY_WITH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |-> (status[3:0] != 4'b0000)); // R6

endmodule

// File: tb/lcd_frame_timer_bench.sv
module lcd_frame_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] htime = 8'd0;
    logic       dot_sel = 1'b0;
    logic [1:0] vsize = 2'b00;
    logic [3:0] vwidth = 4'd0;
    logic       line_stb, frame_stb, vblank, irq;
    logic [7:0] status;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_frame_timer u_lcd_frame_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .htime(htime), .dot_sel(dot_sel),
        .vsize(vsize), .vwidth(vwidth), .line_stb(line_stb), .frame_stb(frame_stb),
        .vblank(vblank), .irq(irq), .status(status)
    );

    // reference model state
    int         m_state = 0;   // 0 idle, 1 visible, 2 blank
    int         m_dot = 0, m_rep = 0, m_ln = 0;
    int         m_h = 0;
    bit         m_dsel = 0;
    bit [1:0]   m_vs = 0;
    bit [3:0]   m_vw = 0;
    bit         m_line = 0, m_frame = 0, m_irq = 0;
    int         m_done_lines = 0, m_done_irq = 0;
    int         fr_lines = 0, fr_irq = 0;

    function automatic int f_shift(input bit d);
        return d ? 50 : 40;
    endfunction

    function automatic int f_vis(input bit [1:0] c);
        return (c == 2'b00) ? 100 : (c == 2'b01) ? 160 : 200;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic model_load();
        m_h = htime; m_dsel = dot_sel; m_vs = vsize; m_vw = vwidth;
    endtask

    task automatic model_update();
        m_line = 0; m_frame = 0; m_irq = 0;
        if (m_state == 0) begin
            if (tick) begin
                model_load();
                m_state = 1; m_dot = 0; m_rep = 0; m_ln = 0;
            end
        end else if (tick) begin
            if (m_dot == f_shift(m_dsel) - 1) begin
                m_dot = 0;
                if (m_rep == m_h) begin
                    m_rep = 0;
                    m_line = 1;
                    if (m_state == 1 && m_ln == f_vis(m_vs) - 1 && m_vw != 0) begin
                        m_state = 2; m_irq = 1; m_ln++;
                    end else if (m_ln == f_vis(m_vs) + m_vw - 1) begin
                        m_frame = 1;
                        m_done_lines = f_vis(m_vs) + m_vw;
                        m_done_irq = (m_vw != 0);
                        m_state = 1; m_ln = 0;
                        model_load();
                    end else begin
                        m_ln++;
                    end
                end else begin
                    m_rep++;
                end
            end else begin
                m_dot++;
            end
        end
    endtask

    task automatic compare();
        logic [7:0] exp_stat;
        exp_stat = {(m_state == 2), 1'b0, m_vs, m_vw};
        check(line_stb == m_line, "R2 line_stb", line_stb, m_line);
        check(frame_stb == m_frame, "R8 frame_stb", frame_stb, m_frame);
        check(irq == m_irq, "R5 irq", irq, m_irq);
        check(vblank == (m_state == 2), "R4 vblank", vblank, m_state == 2);
        check(status == exp_stat, "R9 status", status, exp_stat);
        if (line_stb) fr_lines++;
        if (irq) fr_irq++;
        if (frame_stb) begin
            check(fr_lines == m_done_lines, "R3 lines per frame", fr_lines, m_done_lines);
            check(fr_irq == m_done_irq, "R6 irq per frame", fr_irq, m_done_irq);
            fr_lines = 0; fr_irq = 0;
        end
    endtask

    // inputs for the coming edge are already set; advance model, then sample
    task automatic step(input bit t);
        tick = t;
        model_update();
        @(negedge clk);
        cycles++;
        compare();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle with no ticks
        htime = 8'd0; dot_sel = 1'b0; vsize = 2'b00; vwidth = 4'd3;
        for (int i = 0; i < 5; i++) begin
            step(1'b0);
            check({line_stb, frame_stb, irq, vblank} == 4'b0, "R1 idle outputs", {line_stb, frame_stb, irq, vblank}, 0);
            check(status == 8'h00, "R1 idle status", status, 0);
        end
        // R2 R4 R5: 100 visible + 3 blank lines, 40 ticks per line
        for (int i = 0; i < 9000; i++) step(1'b1);
        // R7: mid-frame change must not reach the status view yet
        vsize = 2'b01; vwidth = 4'd0; htime = 8'd1;
        step(1'b1);
        check(status[5:0] == 6'h03, "R7 mid-frame change ignored", status[5:0], 6'h03);
        // R6: zero blank width, 160 lines
        for (int i = 0; i < 14000; i++) step(1'b1);
        // R3: reserved size code, wide dots, full blank width
        vsize = 2'b11; vwidth = 4'd15; htime = 8'd0; dot_sel = 1'b1;
        for (int i = 0; i < 24000; i++) step(1'b1);
        // random phase: sparse ticks and occasional config changes
        for (int i = 0; i < 90000; i++) begin
            if ($urandom_range(0, 499) == 0) begin
                htime   = 8'($urandom_range(0, 1));
                dot_sel = 1'($urandom_range(0, 1));
                vsize   = 2'($urandom_range(0, 3));
                vwidth  = ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(1, 15));
            end
            step(1'($urandom_range(0, 3) != 0));
        end
        finish_run();
    end

endmodule